// File: doc/BRIEF.md
# Prioritized Core Interrupt Latch, Mask and Service Tracker

This block keeps the core-side bookkeeping for a handful of prioritized interrupt sources, such as a periodic timer tick. Each source has a latch bit, a mask bit and an in-service bit. A request pulse always sets its latch bit, even while the source is masked, so the event is not lost and can be taken once software enables it. Software writes the whole mask at once. It can also discard latched events by writing ones to a clear port.

Priority is fixed: source 0 ranks highest. Among the sources that are both latched and enabled, the block picks the one with the lowest index. It raises an interrupt to the core only when that source outranks every source already in service, so only a more urgent source can nest on top of a running handler. When the core accepts the interrupt, the block clears the latch bit and sets the in-service bit in the same edge. A return-from-interrupt strobe retires the most urgent in-service source. The in-service register has no write path.

Top module: `icCore`

## Requirements
- R1: While reset is asserted and on the first cycle after it, latchQ, maskQ and pendQ are all zero and intReq is low.
- R2: A 1 on irqIn[i] at a clock edge sets latchQ[i] from that edge onward, whatever maskQ[i] holds.
- R3: A maskWrEn strobe loads maskWrData into maskQ at that edge. intReq is asserted only for a source whose latchQ and maskQ bits are both 1.
- R4: When several latched and enabled sources exist, intIdx shows the lowest index among them.
- R5: intReq is high only when the selected index is strictly lower than the index of every set bit in pendQ.
- R6: intAck at an edge where intReq is high clears latchQ[intIdx] and sets pendQ[intIdx] at that edge. intAck while intReq is low changes nothing.
- R7: A 1 on irqIn[i] in the same cycle that bit i is cleared, either by accept or by a software clear, leaves latchQ[i] set.
- R8: rtiStrobe clears the lowest-index set bit of pendQ and leaves the other bits unchanged. With pendQ zero, rtiStrobe has no effect.
- R9: latchClrEn clears every latchQ bit whose latchClrData bit is 1. Bits written 0 are unchanged.
- R10: pendQ changes only through accept and return. Mask writes and latch clears never alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | NUM_SRC | Request pulses, one per source |
| maskWrEn | input | 1 | Load the mask register |
| maskWrData | input | NUM_SRC | New mask value, 1 enables the source |
| latchClrEn | input | 1 | Apply a write-one-to-clear to the latch |
| latchClrData | input | NUM_SRC | Latch bits to clear |
| intAck | input | 1 | Core accepts the requested interrupt |
| rtiStrobe | input | 1 | Core returns from the current interrupt |
| intReq | output | 1 | Interrupt request to the core |
| intIdx | output | IDX_W | Index of the requested source |
| latchQ | output | NUM_SRC | Latch register |
| maskQ | output | NUM_SRC | Mask register |
| pendQ | output | NUM_SRC | In-service register, read-only |

## Verification
Every register update lands on the edge that samples its strobe. intReq and intIdx are combinational from the registers, so any stimulus shows at the outputs right after the next rising edge, with no further latency. The bench drives inputs one time unit after an edge and reads all outputs one time unit after the following edge. Each expected value is therefore due exactly one edge after its cause. The sweeps cover every nonzero latch pattern for the priority choice and every pair of in-service and candidate source for preemption.

// File: rtl/icPkg.sv
package icPkg;
  typedef struct packed {
    logic ackFire;
    logic rtiFire;
    logic maskWr;
    logic latchClr;
  } icStrobes_t;
endpackage

// File: rtl/icPrioEnc.sv
module icPrioEnc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec,
  output logic               valid,
  output logic [IDX_W-1:0]   idx,
  output logic [NUM_SRC-1:0] oneHot
);
  always_comb begin
    valid  = |vec;
    idx    = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    oneHot = vec & (~vec + NUM_SRC'(1));
  end
endmodule

// File: rtl/icCtrl.sv
module icCtrl
  import icPkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] latchQ,
  input  logic [NUM_SRC-1:0] maskQ,
  input  logic [NUM_SRC-1:0] pendQ,
  input  logic               intAck,
  input  logic               rtiStrobe,
  input  logic               maskWrEn,
  input  logic               latchClrEn,
  output logic               intReq,
  output logic [IDX_W-1:0]   intIdx,
  output logic [NUM_SRC-1:0] candOneHot,
  output logic [NUM_SRC-1:0] pendOneHot,
  output icStrobes_t         strobes
);
  logic [NUM_SRC-1:0] candVec;
  logic               candValid;
  logic               pendValid;
  logic [IDX_W-1:0]   pendIdx;

  assign candVec = latchQ & maskQ;

  icPrioEnc #(.NUM_SRC(NUM_SRC)) u_candEnc (
    .vec(candVec), .valid(candValid), .idx(intIdx), .oneHot(candOneHot)
  );

  icPrioEnc #(.NUM_SRC(NUM_SRC)) u_pendEnc (
    .vec(pendQ), .valid(pendValid), .idx(pendIdx), .oneHot(pendOneHot)
  );

  always_comb begin
    intReq = candValid && (!pendValid || (intIdx < pendIdx));
    strobes.ackFire  = intAck && intReq;
    strobes.rtiFire  = rtiStrobe && pendValid;
    strobes.maskWr   = maskWrEn;
    strobes.latchClr = latchClrEn;
  end
endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import icPkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  icStrobes_t         strobes,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic [NUM_SRC-1:0] latchClrData,
  input  logic [NUM_SRC-1:0] candOneHot,
  input  logic [NUM_SRC-1:0] pendOneHot,
  output logic [NUM_SRC-1:0] latchQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] pendQ
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic clrBit;
    assign clrBit = (strobes.ackFire && candOneHot[i]) ||
                    (strobes.latchClr && latchClrData[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchQ[i] <= 1'b0;
        maskQ[i]  <= 1'b0;
        pendQ[i]  <= 1'b0;
      end else begin
        latchQ[i] <= irqIn[i] || (latchQ[i] && !clrBit);
        if (strobes.maskWr) maskQ[i] <= maskWrData[i];
        pendQ[i]  <= (strobes.ackFire && candOneHot[i]) ||
                     (pendQ[i] && !(strobes.rtiFire && pendOneHot[i]));
      end
    end
  end
endmodule

// File: rtl/icCore.sv
module icCore
  import icPkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               latchClrEn,
  input  logic [NUM_SRC-1:0] latchClrData,
  input  logic               intAck,
  input  logic               rtiStrobe,
  output logic               intReq,
  output logic [IDX_W-1:0]   intIdx,
  output logic [NUM_SRC-1:0] latchQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] pendQ
);
  icStrobes_t         strobes;
  logic [NUM_SRC-1:0] candOneHot;
  logic [NUM_SRC-1:0] pendOneHot;

  icCtrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .latchQ(latchQ), .maskQ(maskQ), .pendQ(pendQ),
    .intAck(intAck), .rtiStrobe(rtiStrobe),
    .maskWrEn(maskWrEn), .latchClrEn(latchClrEn),
    .intReq(intReq), .intIdx(intIdx),
    .candOneHot(candOneHot), .pendOneHot(pendOneHot),
    .strobes(strobes)
  );

  icDatapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .irqIn(irqIn), .maskWrData(maskWrData), .latchClrData(latchClrData),
    .candOneHot(candOneHot), .pendOneHot(pendOneHot),
    .latchQ(latchQ), .maskQ(maskQ), .pendQ(pendQ)
  );
endmodule

// File: rtl/icCore_chk.sv
module icCore_chk #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqIn,
  input logic               maskWrEn,
  input logic               latchClrEn,
  input logic               intAck,
  input logic               rtiStrobe,
  input logic               intReq,
  input logic [IDX_W-1:0]   intIdx,
  input logic [NUM_SRC-1:0] latchQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] pendQ
);
  logic [NUM_SRC-1:0] belowSel;
  logic [NUM_SRC-1:0] atOrBelowSel;

  always_comb begin
    belowSel     = (NUM_SRC'(1) << intIdx) - NUM_SRC'(1);
    atOrBelowSel = ((NUM_SRC'(1) << intIdx) << 1) - NUM_SRC'(1);
  end

  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqIn != '0) |=> ((latchQ & $past(irqIn)) == $past(irqIn)));

  // R3
  req_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (latchQ[intIdx] && maskQ[intIdx]));

  // R4
  req_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((latchQ & maskQ & belowSel) == '0));

  // R5
  req_preempt_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((pendQ & atOrBelowSel) == '0));

  // R6
  ack_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |=> pendQ[$past(intIdx)]);

  // R8
  rti_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rtiStrobe && !intAck && (pendQ != '0)) |=>
      ($countones(pendQ) + 1 == $countones($past(pendQ))));

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!intAck && !rtiStrobe && (maskWrEn || latchClrEn)) |=> $stable(pendQ));
endmodule

bind icCore icCore_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskWrEn(maskWrEn),
  .latchClrEn(latchClrEn), .intAck(intAck), .rtiStrobe(rtiStrobe),
  .intReq(intReq), .intIdx(intIdx), .latchQ(latchQ), .maskQ(maskQ),
  .pendQ(pendQ)
);

// File: tb/icCore_tb.sv
module icCore_tb;
  localparam int N = 8;
  localparam int IW = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] irqIn = '0;
  logic         maskWrEn = 1'b0;
  logic [N-1:0] maskWrData = '0;
  logic         latchClrEn = 1'b0;
  logic [N-1:0] latchClrData = '0;
  logic         intAck = 1'b0;
  logic         rtiStrobe = 1'b0;
  logic         intReq;
  logic [IW-1:0] intIdx;
  logic [N-1:0] latchQ, maskQ, pendQ;

  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  icCore #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .latchClrEn(latchClrEn),
    .latchClrData(latchClrData), .intAck(intAck), .rtiStrobe(rtiStrobe),
    .intReq(intReq), .intIdx(intIdx), .latchQ(latchQ), .maskQ(maskQ),
    .pendQ(pendQ)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lowestBit(input logic [N-1:0] v);
    for (int i = N - 1; i >= 0; i--) if (v[i]) lowestBit = i;
    if (v == '0) lowestBit = 0;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    irqIn = '0; maskWrEn = 1'b0; latchClrEn = 1'b0; intAck = 1'b0; rtiStrobe = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic setMask(input logic [N-1:0] m);
    maskWrEn = 1'b1; maskWrData = m; tick(); maskWrEn = 1'b0;
  endtask

  // Replace latch contents in one edge: clear all, set v (request wins, R7)
  task automatic loadLatch(input logic [N-1:0] v);
    latchClrEn = 1'b1; latchClrData = '1; irqIn = v; tick();
    latchClrEn = 1'b0; irqIn = '0;
  endtask

  task automatic ackOnce();
    intAck = 1'b1; tick(); intAck = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    tick();
    check("R1 latch in reset", 32'(latchQ), 0);
    check("R1 pend in reset", 32'(pendQ), 0);
    doReset();
    check("R1 latch", 32'(latchQ), 0);
    check("R1 mask", 32'(maskQ), 0);
    check("R1 pend", 32'(pendQ), 0);
    check("R1 intReq", 32'(intReq), 0);

    // R2, R3: latching while masked, then enabling
    for (int i = 0; i < N; i++) begin
      doReset();
      irqIn = N'(1) << i; tick(); irqIn = '0;
      check("R2 latched while masked", 32'(latchQ), 32'(N'(1) << i));
      check("R3 no req when masked", 32'(intReq), 0);
      setMask(N'(1) << i);
      check("R3 mask loaded", 32'(maskQ), 32'(N'(1) << i));
      check("R3 req when enabled", 32'(intReq), 1);
      check("R3 idx", 32'(intIdx), 32'(i));
      setMask(~(N'(1) << i));
      check("R3 req dropped", 32'(intReq), 0);
    end

    // R4, R7: every latch pattern with all sources enabled
    doReset();
    setMask('1);
    for (int v = 1; v < (1 << N); v++) begin
      loadLatch(N'(v));
      check("R7 request beats clear", 32'(latchQ), 32'(v));
      check("R4 req", 32'(intReq), 1);
      check("R4 lowest idx", 32'(intIdx), 32'(lowestBit(N'(v))));
    end
    // R9: clear everything
    latchClrEn = 1'b1; latchClrData = '1; tick(); latchClrEn = 1'b0;
    check("R9 all cleared", 32'(latchQ), 0);
    check("R9 no req", 32'(intReq), 0);

    // R9: partial write-one-to-clear
    doReset();
    irqIn = 8'hF0; tick(); irqIn = '0;
    latchClrEn = 1'b1; latchClrData = 8'h30; tick(); latchClrEn = 1'b0;
    check("R9 partial clear", 32'(latchQ), 32'h C0);

    // R6: ack without request
    doReset();
    ackOnce();
    check("R6 ack ignored pend", 32'(pendQ), 0);
    check("R6 ack ignored latch", 32'(latchQ), 0);

    // R6, R5: accept p, then every other candidate
    for (int p = 0; p < N; p++) begin
      doReset();
      setMask('1);
      irqIn = N'(1) << p; tick(); irqIn = '0;
      ackOnce();
      check("R6 pend set", 32'(pendQ), 32'(N'(1) << p));
      check("R6 latch cleared", 32'(latchQ), 0);
      check("R6 req low", 32'(intReq), 0);
      for (int c = 0; c < N; c++) begin
        if (c != p) begin
          loadLatch(N'(1) << c);
          check("R5 preempt only higher", 32'(intReq), 32'(c < p));
        end
      end
    end

    // R7: new request on the accept edge of the same source
    doReset();
    setMask('1);
    irqIn = 8'h08; tick();
    intAck = 1'b1; tick(); intAck = 1'b0; irqIn = '0;
    check("R7 pend set", 32'(pendQ), 32'h08);
    check("R7 latch kept", 32'(latchQ), 32'h08);

    // R8, R10: nesting and return
    doReset();
    setMask('1);
    irqIn = 8'h20; tick(); irqIn = '0;
    ackOnce();
    irqIn = 8'h04; tick(); irqIn = '0;
    check("R5 nested req", 32'(intReq), 1);
    check("R5 nested idx", 32'(intIdx), 2);
    ackOnce();
    check("R6 nested pend", 32'(pendQ), 32'h24);
    setMask('0);
    check("R10 mask write", 32'(pendQ), 32'h24);
    latchClrEn = 1'b1; latchClrData = '1; tick(); latchClrEn = 1'b0;
    check("R10 latch clear", 32'(pendQ), 32'h24);
    rtiStrobe = 1'b1; tick(); rtiStrobe = 1'b0;
    check("R8 first return", 32'(pendQ), 32'h20);
    rtiStrobe = 1'b1; tick(); rtiStrobe = 1'b0;
    check("R8 second return", 32'(pendQ), 0);
    rtiStrobe = 1'b1; tick(); rtiStrobe = 1'b0;
    check("R8 return when idle", 32'(pendQ), 0);
    check("R8 latch untouched", 32'(latchQ), 0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule